// File: doc/BRIEF.md
# Reload down-timer with byte-latched readback

This block is a 16-bit down-counter that reloads from a software-set value. It hangs off an 8-bit register bus. Address 0 reaches the low byte and address 1 the high byte. A write to either address goes into the reload value. A read from either address goes to the count. The running count cannot be written by the bus. It only takes the reload value, either on a software start or when it counts through zero. When the count underflows, a sticky flag is set.

Software reads the count a byte at a time while it runs. Reading the high byte first also captures the low byte of that same count into a shadow register. A later low-byte read returns the shadow, so the two bytes come from one instant. A separate 16-bit output shows the live count for logic beside the timer. It has no effect on the shadow.

The bus uses plain strobes, with no back-pressure. The block accepts every read and write in the cycle it is presented. Read data comes back exactly one cycle after the read strobe, marked by a one-cycle valid pulse. The count-tick input and the flag output are plain level signals.

Top module: `rtm_timer`

## Requirements
- R1: After reset the count, reload value, shadow byte, enable bit and underflow flag are all 0, so `count_o`, `underflow_o` and every register read return 0.
- R2: A write to address 0 sets bits 7:0 of the reload value, and a write to address 1 sets bits 15:8. Neither write changes the running count.
- R3: Address 2 is the control byte. A write with bit 1 (start) = 1 and bit 0 (enable) = 1 loads the count from the reload value at that clock edge. A start written with bit 0 = 0 is ignored and leaves the count unchanged. Bit 0 of every control write becomes the enable bit.
- R4: The count decrements by one at each clock edge where `tick` is 1 and the enable bit is 1. With the enable bit at 0, ticks leave the count frozen.
- R5: A tick that arrives while enabled with the count at 0 reloads the count from the reload value and sets the underflow flag. The flag is seen on `underflow_o` and as bit 2 of a control read. A control write with bit 2 = 1 clears the flag. If an underflow happens in the same cycle as a clear, the flag stays set.
- R6: A read of address 1 returns bits 15:8 of the live count and copies bits 7:0 of that same count into the shadow. A read of address 0 returns the shadow, not the live low byte.
- R7: Read data appears on `bus_rdata` with `bus_rvalid` = 1 in the cycle after `bus_rd`. A control read returns enable in bit 0, the underflow flag in bit 2 and 0 in every other bit (start reads 0). Address 3 reads 0.
- R8: When a start and an enabled tick fall in the same cycle, the count takes the reload value and does not decrement in that cycle.
- R9: `count_o` always shows the live 16-bit count and has no effect on the shadow byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the strobe |
| bus_rvalid | output | 1 | Pulse marking valid read data |
| tick | input | 1 | Count-enable tick |
| count_o | output | 16 | Live count |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
Errors in the count register show up on `count_o` at the very next edge. A wrong reload, a lost tick or a write that leaks into the count therefore differs from the expected sequence within one cycle. A bad shadow cannot be seen until the next low-byte read, so the checks read low bytes that are stale, after the count has moved on. This separates the shadow from the live value. A flag that fails to set or clear is visible at once on `underflow_o`. It shows one cycle after a control read on the bus.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  // Register addresses on the byte bus
  localparam int unsigned ADDR_LO  = 0;
  localparam int unsigned ADDR_HI  = 1;
  localparam int unsigned ADDR_CTL = 2;
  // Bit positions inside the control byte
  localparam int unsigned CTL_EN    = 0;
  localparam int unsigned CTL_START = 1;
  localparam int unsigned CTL_UF    = 2;
endpackage

// File: rtl/rtm_reload_regs.sv
module rtm_reload_regs #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned CNT_W = BUS_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [CNT_W-1:0]  reload
);
  // One byte lane per bus address; lane g answers address g
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BUS_W-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= '0;
      end else if (wr && (addr == ADDR_W'(g))) begin
        lane_q <= wdata;
      end
    end
    assign reload[g*BUS_W +: BUS_W] = lane_q;
  end
endmodule

// File: rtl/rtm_ctrl.sv
module rtm_ctrl
  import rtm_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_bit,
  input  logic              start_bit,
  input  logic              clr_bit,
  input  logic              uf_set,
  output logic              en,
  output logic              start,
  output logic              uf
);
  logic ctl_wr;

  assign ctl_wr = wr && (addr == ADDR_W'(ADDR_CTL));
  // A start only counts when the same write leaves counting enabled
  assign start  = ctl_wr && start_bit && en_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
    end else if (ctl_wr) begin
      en <= en_bit;
    end
  end

  // Setting wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf <= 1'b0;
    end else if (uf_set) begin
      uf <= 1'b1;
    end else if (ctl_wr && clr_bit) begin
      uf <= 1'b0;
    end
  end
endmodule

// File: rtl/rtm_counter.sv
module rtm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             uf_set
);
  logic step;

  assign step   = en && tick && !start;
  assign uf_set = step && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (start) begin
      count <= reload;
    end else if (step) begin
      if (count == '0) begin
        count <= reload;
      end else begin
        count <= count - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtm_readback.sv
module rtm_readback
  import rtm_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              en,
  input  logic              uf,
  output logic [BUS_W-1:0]  rdata,
  output logic              rvalid,
  output logic [BUS_W-1:0]  shadow
);
  logic [BUS_W-1:0] ctl_byte;
  logic [BUS_W-1:0] rd_mux;

  always_comb begin
    ctl_byte         = '0;
    ctl_byte[CTL_EN] = en;
    ctl_byte[CTL_UF] = uf;
  end

  always_comb begin
    if (addr == ADDR_W'(ADDR_LO)) begin
      rd_mux = shadow;
    end else if (addr == ADDR_W'(ADDR_HI)) begin
      rd_mux = count[CNT_W-1 -: BUS_W];
    end else if (addr == ADDR_W'(ADDR_CTL)) begin
      rd_mux = ctl_byte;
    end else begin
      rd_mux = '0;
    end
  end

  // High-byte read freezes the matching low byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
    end else if (rd && (addr == ADDR_W'(ADDR_HI))) begin
      shadow <= count[BUS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) begin
        rdata <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/rtm_timer.sv
module rtm_timer
  import rtm_pkg::*;
#(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned CNT_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  input  logic              tick,
  output logic [CNT_W-1:0]  count_o,
  output logic              underflow_o
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic [BUS_W-1:0] shadow;
  logic             en;
  logic             start;
  logic             uf;
  logic             uf_set;

  rtm_reload_regs #(.BUS_W(BUS_W), .LANES(2), .ADDR_W(ADDR_W)) u_reload (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .reload (reload)
  );

  rtm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .en_bit    (bus_wdata[CTL_EN]),
    .start_bit (bus_wdata[CTL_START]),
    .clr_bit   (bus_wdata[CTL_UF]),
    .uf_set    (uf_set),
    .en        (en),
    .start     (start),
    .uf        (uf)
  );

  rtm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .en     (en),
    .tick   (tick),
    .reload (reload),
    .count  (count),
    .uf_set (uf_set)
  );

  rtm_readback #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_readback (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (bus_rd),
    .addr   (bus_addr),
    .count  (count),
    .en     (en),
    .uf     (uf),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid),
    .shadow (shadow)
  );

  assign count_o     = count;
  assign underflow_o = uf;
endmodule

// File: rtl/rtm_timer_chk.sv
module rtm_timer_chk #(
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned CNT_W = 2 * BUS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              tick,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              bus_rvalid,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  reload,
  input logic [BUS_W-1:0]  shadow,
  input logic              en,
  input logic              start,
  input logic              uf
);
  // R2
  reload_write_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr < ADDR_W'(2) && !tick) |=> $stable(count));
  // R3
  start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == $past(reload)));
  // R4
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start) |=> $stable(count));
  // R4
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !start && count != '0) |=> (count == $past(count) - 1'b1));
  // R5
  underflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !start && count == '0) |=> (uf && count == $past(reload)));
  // R6
  shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(1)) |=>
      (shadow == $past(count[BUS_W-1:0]) && bus_rdata == $past(count[CNT_W-1:BUS_W])));
  // R6
  low_from_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(0)) |=> (bus_rdata == $past(shadow)));
  // R7
  rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  // R7
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
endmodule

bind rtm_timer rtm_timer_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .tick       (tick),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .count      (count),
  .reload     (reload),
  .shadow     (shadow),
  .en         (en),
  .start      (start),
  .uf         (uf)
);

// File: tb/rtm_timer_bench.sv
module rtm_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 40;
  // Vector: {req[3:0], kind[1:0], addr[1:0], val[8:0]}
  // kind 0 write val, 1 read expect val, 2 tick val cycles, 3 expect underflow_o = val[0]
  localparam logic [16:0] VEC [0:NVEC-1] = '{
    {4'd2, 2'd0, 2'd0, 9'h005}, {4'd2, 2'd0, 2'd1, 9'h001},
    {4'd2, 2'd1, 2'd1, 9'h000}, {4'd2, 2'd1, 2'd0, 9'h000},
    {4'd3, 2'd0, 2'd2, 9'h003}, {4'd3, 2'd1, 2'd1, 9'h001},
    {4'd6, 2'd1, 2'd0, 9'h005}, {4'd4, 2'd2, 2'd0, 9'd3},
    {4'd7, 2'd1, 2'd2, 9'h001}, {4'd4, 2'd1, 2'd1, 9'h001},
    {4'd4, 2'd1, 2'd0, 9'h002}, {4'd4, 2'd2, 2'd0, 9'd5},
    {4'd6, 2'd1, 2'd0, 9'h002}, {4'd6, 2'd1, 2'd1, 9'h000},
    {4'd6, 2'd1, 2'd0, 9'h0FD}, {4'd2, 2'd0, 2'd0, 9'h002},
    {4'd2, 2'd0, 2'd1, 9'h000}, {4'd2, 2'd1, 2'd1, 9'h000},
    {4'd2, 2'd1, 2'd0, 9'h0FD}, {4'd5, 2'd2, 2'd0, 9'd254},
    {4'd5, 2'd3, 2'd0, 9'h001}, {4'd5, 2'd1, 2'd2, 9'h005},
    {4'd5, 2'd1, 2'd1, 9'h000}, {4'd5, 2'd1, 2'd0, 9'h002},
    {4'd5, 2'd0, 2'd2, 9'h005}, {4'd5, 2'd1, 2'd2, 9'h001},
    {4'd5, 2'd3, 2'd0, 9'h000}, {4'd4, 2'd0, 2'd2, 9'h000},
    {4'd4, 2'd2, 2'd0, 9'd4},   {4'd4, 2'd1, 2'd1, 9'h000},
    {4'd4, 2'd1, 2'd0, 9'h002}, {4'd3, 2'd0, 2'd0, 9'h040},
    {4'd3, 2'd0, 2'd2, 9'h002}, {4'd3, 2'd1, 2'd2, 9'h000},
    {4'd3, 2'd1, 2'd1, 9'h000}, {4'd3, 2'd1, 2'd0, 9'h002},
    {4'd3, 2'd0, 2'd2, 9'h003}, {4'd3, 2'd1, 2'd1, 9'h000},
    {4'd3, 2'd1, 2'd0, 9'h040}, {4'd7, 2'd1, 2'd3, 9'h000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        tick = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [15:0] count_o;
  logic        underflow_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtm_timer u_rtm_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .tick        (tick),
    .count_o     (count_o),
    .underflow_o (underflow_o)
  );

  task automatic check(input int req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input int req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(7, int'(bus_rvalid), 1, "rvalid after read");
    check(req, int'(bus_rdata), int'(exp), $sformatf("read addr %0d", a));
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, int'(count_o), 0, "count after reset");
    check(1, int'(underflow_o), 0, "flag after reset");
    check(1, int'(bus_rvalid), 0, "rvalid after reset");
    bus_read(1, 2'd2, 8'h00);
    bus_read(1, 2'd0, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i][12:11])
        2'd0: bus_write(VEC[i][10:9], VEC[i][7:0]);
        2'd1: bus_read(int'(VEC[i][16:13]), VEC[i][10:9], VEC[i][7:0]);
        2'd2: ticks(int'(VEC[i][8:0]));
        default: check(int'(VEC[i][16:13]), int'(underflow_o), int'(VEC[i][0]), "underflow_o");
      endcase
    end

    // R4 live decrement seen on the word port: 0x40 - 2
    ticks(2);
    check(4, int'(count_o), 'h3E, "count after two ticks");
    // R8 start and tick together: reload wins, no decrement
    @(negedge clk);
    bus_addr = 2'd2; bus_wdata = 8'h03; bus_wr = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick = 1'b0;
    check(8, int'(count_o), 'h40, "start with tick");
    // R9 word port follows the count while the shadow holds the older byte
    bus_read(6, 2'd1, 8'h00);
    ticks(1);
    check(9, int'(count_o), 'h3F, "word port live");
    bus_read(9, 2'd0, 8'h40);

    finish_run();
  end
endmodule